// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers device interrupt lines into two local groups of eight and one shared group of eight "mappable" lines. Each local group has a live status view and a writable enable mask. The group raises its own level-sensitive request to the processor whenever any enabled source in it is active. The mappable group reaches the processor only indirectly. Its one status byte is qualified by two independent enable masks, A and B. Mask A feeds a fixed cascade position in local group 0, and mask B feeds a fixed cascade position in local group 1.

For each local group the block also presents a source vector: the index of the most important pending source, where higher bit numbers win. When the cascade position of a group is the pending source, the vector comes from the masked mappable set instead of the local set. Software reads the status and mask registers and writes the masks through a small word-addressed register port. Enabling any mappable line automatically enables the matching cascade position. Disabling the last one disables it again. Software therefore never manages the cascade enable directly.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset all masks read 0, both request outputs are low and both vector-valid flags are 0, whatever the input lines are.
- R2: Local status registers (address 0 for group 0, 2 for group 1) and the mappable status register (address 4) show the current input levels. Writes to these addresses change no register.
- R3: A group's pending set is its status ANDed with its mask. The group's request output is high exactly when that set is nonzero.
- R4: The vector is the index of the highest-numbered bit in the pending set, with bit 7 the most important and bit 0 the least.
- R5: An empty pending set gives vector 0 with the valid flag at 0.
- R6: The cascade position of a local status register (bit 2 in group 0, bit 3 in group 1) reads 1 exactly when the mappable status ANDed with that group's mappable mask is nonzero. The raw input line at that position is ignored.
- R7: When the cascade position of a group is pending, the vector is the highest set bit of the masked mappable set, even if higher local bits are pending.
- R8: The cascade position of a local mask reads 1 exactly when the matching mappable mask is nonzero. Software writes to that mask position are ignored.
- R9: Mappable mask A affects only group 0 and mappable mask B affects only group 1.
- R10: Register addresses: 1 = mask of group 0, 3 = mask of group 1, 5 = mappable mask A, 6 = mappable mask B. A write updates the register on the next clock edge. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc0_lines_i | input | 8 | Interrupt lines of local group 0 |
| loc1_lines_i | input | 8 | Interrupt lines of local group 1 |
| map_lines_i | input | 8 | Shared mappable interrupt lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address (combinational) |
| irq0_o | output | 1 | Request of local group 0 |
| irq1_o | output | 1 | Request of local group 1 |
| vec0_o | output | 3 | Winning source index of group 0 |
| vec0_vld_o | output | 1 | Group 0 vector valid |
| vec1_o | output | 3 | Winning source index of group 1 |
| vec1_vld_o | output | 1 | Group 1 vector valid |

## Verification
The priority logic is tried with single active lines, with several lines at once where the top one must win, and with lines that are all masked off. Together these separate a correct highest-bit choice from a lowest-bit choice and from ignoring the mask. The cascade is tried three ways. In the first, mappable lines are enabled while a higher local line is active, which shows that the cascade overrides local priority. In the second, mappable lines are active but not enabled, which shows that the cascade bit needs a masked match. In the third, only mask B is set, which shows that the two masks stay separate. Writes of the cascade position into a local mask, writes to status addresses, and clearing a mappable mask show that the cascade enable follows the mappable mask alone.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned GRP_W  = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT0 = 3'd0,
    RA_MASK0 = 3'd1,
    RA_STAT1 = 3'd2,
    RA_MASK1 = 3'd3,
    RA_MSTAT = 3'd4,
    RA_MMSKA = 3'd5,
    RA_MMSKB = 3'd6,
    RA_NONE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/cirq_rst_sync.sv
module cirq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cirq_prio_enc.sv
module cirq_prio_enc #(
  parameter int unsigned W  = 8,
  localparam int unsigned VW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [VW-1:0] idx_o,
  output logic          vld_o
);
  // Higher index overrides lower: the last hit in the ascending scan wins.
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = 0; i < int'(W); i++) begin
      if (req_i[i]) begin
        idx_o = VW'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cirq_mask_bank.sv
module cirq_mask_bank #(
  parameter int unsigned W        = 8,
  parameter int unsigned CASC_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_loc_i,
  input  logic         wr_map_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] loc_mask_o,
  output logic [W-1:0] map_mask_o
);
  localparam logic [W-1:0] CMASK = W'(1) << CASC_BIT;

  logic [W-1:0] loc_q, loc_d;
  logic [W-1:0] map_q, map_d;

  // Next state: the cascade position is never stored in the local mask.
  always_comb begin
    loc_d = loc_q;
    map_d = map_q;
    if (wr_loc_i) loc_d = wdata_i & ~CMASK;
    if (wr_map_i) map_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      map_q <= '0;
    end else begin
      if (wr_loc_i) loc_q <= loc_d;
      if (wr_map_i) map_q <= map_d;
    end
  end

  // The cascade enable follows the mappable mask.
  assign loc_mask_o = loc_q | ((|map_q) ? CMASK : '0);
  assign map_mask_o = map_q;
endmodule

// File: rtl/cirq_group.sv
module cirq_group #(
  parameter int unsigned W        = 8,
  parameter int unsigned CASC_BIT = 2,
  localparam int unsigned VW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  lines_i,
  input  logic [W-1:0]  map_stat_i,
  input  logic [W-1:0]  map_mask_i,
  input  logic [W-1:0]  loc_mask_i,
  output logic [W-1:0]  status_o,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic          vld_o
);
  localparam logic [W-1:0] CMASK = W'(1) << CASC_BIT;

  logic [W-1:0]  map_eff;
  logic [W-1:0]  pend;
  logic [VW-1:0] loc_idx, map_idx;
  logic          loc_vld, map_vld;
  logic          casc_hit;

  assign map_eff  = map_stat_i & map_mask_i;
  assign status_o = (lines_i & ~CMASK) | ((|map_eff) ? CMASK : '0);
  assign pend     = status_o & loc_mask_i;
  assign irq_o    = |pend;
  assign casc_hit = pend[CASC_BIT];

  cirq_prio_enc #(.W(W)) u_loc_enc (
    .req_i (pend),
    .idx_o (loc_idx),
    .vld_o (loc_vld)
  );

  cirq_prio_enc #(.W(W)) u_map_enc (
    .req_i (map_eff),
    .idx_o (map_idx),
    .vld_o (map_vld)
  );

  always_comb begin
    if (casc_hit) begin
      vec_o = map_idx;
      vld_o = map_vld;
    end else begin
      vec_o = loc_idx;
      vld_o = loc_vld;
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int unsigned DW    = cirq_pkg::GRP_W,
  parameter int unsigned CASC0 = 2,
  parameter int unsigned CASC1 = 3,
  localparam int unsigned VW   = (DW > 1) ? $clog2(DW) : 1,
  localparam int unsigned AW   = cirq_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] loc0_lines_i,
  input  logic [DW-1:0] loc1_lines_i,
  input  logic [DW-1:0] map_lines_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq0_o,
  output logic          irq1_o,
  output logic [VW-1:0] vec0_o,
  output logic          vec0_vld_o,
  output logic [VW-1:0] vec1_o,
  output logic          vec1_vld_o
);
  import cirq_pkg::*;

  localparam int unsigned NGRP = 2;

  logic srst_n;
  logic [NGRP-1:0][DW-1:0] lines_w, stat_w, lmask_w, mmask_w;
  logic [NGRP-1:0][VW-1:0] vec_w;
  logic [NGRP-1:0]         irq_w, vld_w, wr_loc_w, wr_map_w;

  cirq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign lines_w[0] = loc0_lines_i;
  assign lines_w[1] = loc1_lines_i;

  // Write decode
  assign wr_loc_w[0] = reg_wr_i && (reg_addr_i == RA_MASK0);
  assign wr_loc_w[1] = reg_wr_i && (reg_addr_i == RA_MASK1);
  assign wr_map_w[0] = reg_wr_i && (reg_addr_i == RA_MMSKA);
  assign wr_map_w[1] = reg_wr_i && (reg_addr_i == RA_MMSKB);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned CB = (g == 0) ? CASC0 : CASC1;

    cirq_mask_bank #(.W(DW), .CASC_BIT(CB)) u_bank (
      .clk        (clk),
      .rst_n      (srst_n),
      .wr_loc_i   (wr_loc_w[g]),
      .wr_map_i   (wr_map_w[g]),
      .wdata_i    (reg_wdata_i),
      .loc_mask_o (lmask_w[g]),
      .map_mask_o (mmask_w[g])
    );

    cirq_group #(.W(DW), .CASC_BIT(CB)) u_grp (
      .lines_i    (lines_w[g]),
      .map_stat_i (map_lines_i),
      .map_mask_i (mmask_w[g]),
      .loc_mask_i (lmask_w[g]),
      .status_o   (stat_w[g]),
      .irq_o      (irq_w[g]),
      .vec_o      (vec_w[g]),
      .vld_o      (vld_w[g])
    );
  end

  // Read mux
  always_comb begin
    case (reg_addr_i)
      RA_STAT0: reg_rdata_o = stat_w[0];
      RA_MASK0: reg_rdata_o = lmask_w[0];
      RA_STAT1: reg_rdata_o = stat_w[1];
      RA_MASK1: reg_rdata_o = lmask_w[1];
      RA_MSTAT: reg_rdata_o = map_lines_i;
      RA_MMSKA: reg_rdata_o = mmask_w[0];
      RA_MMSKB: reg_rdata_o = mmask_w[1];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq0_o     = irq_w[0];
  assign irq1_o     = irq_w[1];
  assign vec0_o     = vec_w[0];
  assign vec1_o     = vec_w[1];
  assign vec0_vld_o = vld_w[0];
  assign vec1_vld_o = vld_w[1];
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CASC0 = 2,
  parameter int unsigned CASC1 = 3,
  parameter int unsigned VW    = 3,
  parameter int unsigned AW    = 3
) (
  input logic          clk,
  input logic          srst_n,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] map_lines_i,
  input logic          irq0_o,
  input logic          irq1_o,
  input logic [VW-1:0] vec0_o,
  input logic          vec0_vld_o,
  input logic [VW-1:0] vec1_o,
  input logic          vec1_vld_o,
  input logic [DW-1:0] st0,
  input logic [DW-1:0] st1,
  input logic [DW-1:0] mk0,
  input logic [DW-1:0] mk1,
  input logic [DW-1:0] mma,
  input logic [DW-1:0] mmb
);
  logic [DW-1:0] ma_eff, mb_eff;
  assign ma_eff = map_lines_i & mma;
  assign mb_eff = map_lines_i & mmb;

  a_r1_masks_clear_at_start: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (mma == '0 && mmb == '0));

  a_r3_irq_matches_valid0: assert property (@(posedge clk) disable iff (!srst_n)
    irq0_o == vec0_vld_o);

  a_r3_irq_matches_valid1: assert property (@(posedge clk) disable iff (!srst_n)
    irq1_o == vec1_vld_o);

  a_r5_idle_vector0: assert property (@(posedge clk) disable iff (!srst_n)
    !vec0_vld_o |-> vec0_o == '0);

  a_r5_idle_vector1: assert property (@(posedge clk) disable iff (!srst_n)
    !vec1_vld_o |-> vec1_o == '0);

  a_r6_cascade_status0: assert property (@(posedge clk) disable iff (!srst_n)
    st0[CASC0] == (|ma_eff));

  a_r6_cascade_status1: assert property (@(posedge clk) disable iff (!srst_n)
    st1[CASC1] == (|mb_eff));

  a_r7_cascade_vector0: assert property (@(posedge clk) disable iff (!srst_n)
    (st0[CASC0] && mk0[CASC0]) |-> (vec0_vld_o && ma_eff[vec0_o]));

  a_r8_cascade_mask0: assert property (@(posedge clk) disable iff (!srst_n)
    mk0[CASC0] == (|mma));

  a_r8_cascade_mask1: assert property (@(posedge clk) disable iff (!srst_n)
    mk1[CASC1] == (|mmb));

  a_r2_status_write_inert: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr_i && reg_addr_i == 3'd0) |=> ($stable(mk0) && $stable(mk1) && $stable(mma) && $stable(mmb)));

  a_r10_write_mask_a: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr_i && reg_addr_i == 3'd5) |=> mma == $past(reg_wdata_i));

  a_r10_write_mask_b: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr_i && reg_addr_i == 3'd6) |=> mmb == $past(reg_wdata_i));
endmodule

bind cascade_irq_ctrl cirq_checker #(
  .DW(DW), .CASC0(CASC0), .CASC1(CASC1), .VW(VW), .AW(AW)
) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .map_lines_i (map_lines_i),
  .irq0_o      (irq0_o),
  .irq1_o      (irq1_o),
  .vec0_o      (vec0_o),
  .vec0_vld_o  (vec0_vld_o),
  .vec1_o      (vec1_o),
  .vec1_vld_o  (vec1_vld_o),
  .st0         (stat_w[0]),
  .st1         (stat_w[1]),
  .mk0         (lmask_w[0]),
  .mk1         (lmask_w[1]),
  .mma         (mmask_w[0]),
  .mmb         (mmask_w[1])
);

// File: tb/sim_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cascade_irq_ctrl;
  localparam int C0 = 2;
  localparam int C1 = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] l0, l1, mp;
  logic       wr;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq0, irq1, vld0, vld1;
  logic [2:0] vec0, vec1;

  always #4 clk = ~clk;

  cascade_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .loc0_lines_i(l0), .loc1_lines_i(l1), .map_lines_i(mp),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq0_o(irq0), .irq1_o(irq1),
    .vec0_o(vec0), .vec0_vld_o(vld0),
    .vec1_o(vec1), .vec1_vld_o(vld1)
  );

  typedef struct {
    int         kind;   // 0 irq0, 1 {vld0,vec0}, 2 irq1, 3 {vld1,vec1}, 4 rdata
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Model state: register contents as the requirements define them
  logic [7:0] m_loc0, m_loc1, m_ma, m_mb;

  // Monitor: compare everything queued for this cycle, away from the edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {7'd0, irq0};
        1: act = {4'd0, vld0, vec0};
        2: act = {7'd0, irq1};
        3: act = {4'd0, vld1, vec1};
        default: act = rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic [3:0] top_bit(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) begin
        r = {1'b1, 3'(i)};
        break;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] m_stat(input logic [7:0] lines, input logic [7:0] mm, input int cb);
    logic [7:0] s;
    s = lines;
    s[cb] = |(mp & mm);
    return s;
  endfunction

  function automatic logic [7:0] m_mask(input logic [7:0] lm, input logic [7:0] mm, input int cb);
    logic [7:0] k;
    k = lm;
    k[cb] = |mm;
    return k;
  endfunction

  function automatic logic [3:0] m_vec(input logic [7:0] lines, input logic [7:0] lm,
                                        input logic [7:0] mm, input int cb);
    logic [7:0] p;
    p = m_stat(lines, mm, cb) & m_mask(lm, mm, cb);
    if (p[cb]) return top_bit(mp & mm);
    return top_bit(p);
  endfunction

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind;
    it.exp = exp;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  // Driver: push expected outputs of both groups for current stimulus
  task automatic check_outs(input string req);
    logic [7:0] p0, p1;
    p0 = m_stat(l0, m_ma, C0) & m_mask(m_loc0, m_ma, C0);
    p1 = m_stat(l1, m_mb, C1) & m_mask(m_loc1, m_mb, C1);
    push(0, {7'd0, |p0}, req);
    push(1, {4'd0, m_vec(l0, m_loc0, m_ma, C0)}, req);
    push(2, {7'd0, |p1}, req);
    push(3, {4'd0, m_vec(l1, m_loc1, m_mb, C1)}, req);
    settle();
  endtask

  task automatic check_read(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    push(4, exp, req);
    settle();
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
    case (a)
      3'd1: m_loc0 = d;
      3'd3: m_loc1 = d;
      3'd5: m_ma = d;
      3'd6: m_mb = d;
      default: ;
    endcase
  endtask

  task automatic set_in(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    l0 = a; l1 = b; mp = m;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = 3'd0; wdata = 8'd0;
    l0 = 8'hFF; l1 = 8'hFF; mp = 8'hFF;
    m_loc0 = 0; m_loc1 = 0; m_ma = 0; m_mb = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: everything masked after reset
    check_outs("R1");
    check_read(3'd1, 8'h00, "R1");
    check_read(3'd5, 8'h00, "R1");
    check_read(3'd6, 8'h00, "R1");

    // R8: cascade position of local mask cannot be written
    wr_reg(3'd1, 8'h85);
    m_loc0 = 8'h81;
    check_read(3'd1, 8'h81, "R8");

    // R3/R4/R5 local priority patterns
    set_in(8'h01, 8'h00, 8'h00); check_outs("R4");
    set_in(8'h81, 8'h00, 8'h00); check_outs("R4");
    set_in(8'h7E, 8'h00, 8'h00); check_outs("R5");
    wr_reg(3'd1, 8'hFB);
    set_in(8'h28, 8'h00, 8'h00); check_outs("R4");
    set_in(8'h00, 8'hFF, 8'h00); check_outs("R3");
    wr_reg(3'd3, 8'h12);
    set_in(8'h00, 8'hFF, 8'h00); check_outs("R3");
    set_in(8'h00, 8'h02, 8'h00); check_outs("R4");

    // R2/R6: status readback, raw cascade line ignored, status writes inert
    set_in(8'h5E, 8'hA5, 8'h3C);
    check_read(3'd0, 8'h5A, "R6");
    check_read(3'd2, 8'hA5 & 8'hF7, "R6");
    check_read(3'd4, 8'h3C, "R2");
    wr_reg(3'd0, 8'hFF);
    wr_reg(3'd4, 8'h00);
    check_read(3'd0, 8'h5A, "R2");
    check_read(3'd1, 8'hFB, "R2");
    check_read(3'd4, 8'h3C, "R2");

    // R7/R8/R9: mappable mask A drives group 0 cascade
    wr_reg(3'd5, 8'h10);
    check_read(3'd1, 8'hFF, "R8");
    check_read(3'd3, 8'h12, "R9");
    set_in(8'h80, 8'h00, 8'h30); check_outs("R7");
    check_read(3'd0, 8'h84, "R6");
    set_in(8'h80, 8'h00, 8'h20); check_outs("R6");
    set_in(8'h00, 8'h00, 8'h10); check_outs("R9");

    // R9: mask B only affects group 1
    wr_reg(3'd6, 8'h01);
    wr_reg(3'd3, 8'hFF);
    check_read(3'd3, 8'hFF, "R8");
    set_in(8'h00, 8'h40, 8'h01); check_outs("R9");
    set_in(8'h00, 8'h00, 8'h11); check_outs("R7");

    // R8: clearing the last mappable bit drops the cascade enable
    wr_reg(3'd5, 8'h00);
    check_read(3'd1, 8'hFB, "R8");
    check_read(3'd5, 8'h00, "R10");
    check_read(3'd6, 8'h01, "R10");
    set_in(8'h04, 8'h00, 8'hFF); check_outs("R8");

    // R10: unused address reads zero
    check_read(3'd7, 8'h00, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule